// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers up to eight device interrupt requests into a pending register and reports them to a host on one level-sensitive interrupt line. Devices raise lines with single-cycle pulses on a set vector and withdraw them with pulses on a clear vector. Software works through a small byte-wide register port. It writes an enable mask, acknowledges one line by index, and reads the pending bits back.

The mask is written in inverted sense: a 1 in the written byte disables its line. The interrupt line is the OR of all pending lines that are also enabled, and it has no priority or vector logic. A second bank of addresses is present so that software written for a cascaded layout keeps working. Its status reads as zero and its writes do nothing.

Address map (3-bit `reg_addr_i`): 0 = bank-0 pending (read), 1 = bank-0 mask (write), 2 = bank-0 acknowledge (write), 4 = bank-1 status (read, always 0), 5 = bank-1 mask (write, ignored), 6 = bank-1 acknowledge (write, ignored). Every address other than 0 reads as zero.

Top module: `masked_irq_ctl`

## Requirements
- R1: After reset the pending and enable registers are zero, `irq_o` is low and a read of address 0 returns zero.
- R2: A write to address 1 stores the bitwise complement of `reg_wdata_i` as the enable mask, so bit i is enabled when written bit i is 0.
- R3: A write to address 2 clears the pending bit whose index is `reg_wdata_i[3:0]`. Index values 8 to 15 clear nothing, and bits 7:4 of the data are ignored.
- R4: `irq_o` is high exactly when some bit is both pending and enabled. It takes its new value in the cycle after the clock edge that captured the causing write or pulse.
- R5: A mask write alone moves `irq_o`. Enabling an already pending line raises it, and disabling every pending line drops it.
- R6: Each 1 bit of `hw_set_i` sets that pending bit at the next clock edge. Other bits keep their value.
- R7: Each 1 bit of `hw_clr_i` clears that pending bit at the next clock edge.
- R8: When a set and a clear (hardware clear or acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R9: A read of address 0 returns the pending byte zero-extended on the 64-bit `reg_rdata_o`. A byte reader uses bits 7:0, a wide reader uses all 64 bits, and bits 63:8 are always zero.
- R10: Address 4 reads as 0x00, and other addresses also read zero. Writes to addresses 5 and 6 change neither pending, mask nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i` (combinational) |
| hw_set_i | input | 8 | Device set pulses, one bit per line |
| hw_clr_i | input | 8 | Device clear pulses, one bit per line |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Pending and mask are registered, while the read data and `irq_o` are decoded from those registers without further delay. A write or pulse captured at one rising edge is therefore visible on both outputs right after that edge. The bench drives stimulus at the falling edge and samples 1 ns after the following rising edge. It first returns the address to 0 and the strobes to idle, then reads the pending byte and the interrupt line in that same cycle, before any later edge.

// File: rtl/masked_irq_pkg.sv
package masked_irq_pkg;
    parameter int IRQ_LINES = 8;
    parameter int DATA_W    = 8;
    parameter int ADDR_W    = 3;
    parameter int RDATA_W   = 64;
    parameter int IDX_W     = 4;

    localparam logic [ADDR_W-1:0] A_PEND0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_ACK0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT1 = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK1 = 3'd5;
    localparam logic [ADDR_W-1:0] A_ACK1  = 3'd6;

    typedef struct packed {
        logic [IRQ_LINES-1:0] pend;
        logic [IRQ_LINES-1:0] en;
    } irq_state_t;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import masked_irq_pkg::*;
(
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 mask_we_o,
    output logic [IRQ_LINES-1:0] mask_en_o,
    output logic [IRQ_LINES-1:0] ack_vec_o
);
    logic                ack_we;
    logic [IDX_W-1:0]    ack_idx;

    assign mask_we_o = wr_i && (addr_i == A_MASK0);
    assign mask_en_o = ~wdata_i[IRQ_LINES-1:0];
    assign ack_we    = wr_i && (addr_i == A_ACK0);
    assign ack_idx   = wdata_i[IDX_W-1:0];

    for (genvar i = 0; i < IRQ_LINES; i++) begin : g_ack
        assign ack_vec_o[i] = ack_we && (ack_idx == IDX_W'(i));
    end
endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
    import masked_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we_i,
    input  logic [IRQ_LINES-1:0] mask_en_i,
    input  logic [IRQ_LINES-1:0] ack_vec_i,
    input  logic [IRQ_LINES-1:0] set_i,
    input  logic [IRQ_LINES-1:0] clr_i,
    output logic [IRQ_LINES-1:0] pend_o,
    output logic [IRQ_LINES-1:0] en_o
);
    irq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // clears first, then sets so that a set wins on a collision
        state_d.pend = (state_q.pend & ~(clr_i | ack_vec_i)) | set_i;
        if (mask_we_i) begin
            state_d.en = mask_en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend;
    assign en_o   = state_q.en;
endmodule

// File: rtl/masked_irq_ctl.sv
module masked_irq_ctl
    import masked_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [RDATA_W-1:0]   reg_rdata_o,
    input  logic [IRQ_LINES-1:0] hw_set_i,
    input  logic [IRQ_LINES-1:0] hw_clr_i,
    output logic                 irq_o
);
    logic                 mask_we;
    logic [IRQ_LINES-1:0] mask_en;
    logic [IRQ_LINES-1:0] ack_vec;
    logic [IRQ_LINES-1:0] pend;
    logic [IRQ_LINES-1:0] en;

    irq_wr_decode u_dec (
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .mask_we_o (mask_we),
        .mask_en_o (mask_en),
        .ack_vec_o (ack_vec)
    );

    irq_pend_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask_we),
        .mask_en_i (mask_en),
        .ack_vec_i (ack_vec),
        .set_i     (hw_set_i),
        .clr_i     (hw_clr_i),
        .pend_o    (pend),
        .en_o      (en)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_PEND0) begin
            reg_rdata_o = RDATA_W'(pend);
        end
    end

    assign irq_o = |(pend & en);
endmodule

// File: rtl/masked_irq_ctl_chk.sv
module masked_irq_ctl_chk
    import masked_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [DATA_W-1:0]    reg_wdata_i,
    input logic [IRQ_LINES-1:0] hw_set_i,
    input logic [IRQ_LINES-1:0] hw_clr_i,
    input logic [IRQ_LINES-1:0] pend,
    input logic [IRQ_LINES-1:0] en,
    input logic                 irq_o
);
    assert_mask_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_MASK0) |=> (en == ~$past(reg_wdata_i)));

    assert_ack_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_ACK0 && !reg_wdata_i[3]
         && !hw_set_i[reg_wdata_i[2:0]]) |=> !pend[$past(reg_wdata_i[2:0])]);

    assert_set_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_i != '0) |=> ((pend & $past(hw_set_i)) == $past(hw_set_i)));

    assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_i != '0) |=> ((pend & $past(hw_clr_i) & ~$past(hw_set_i)) == '0));

    assert_bank1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == A_MASK1 || reg_addr_i == A_ACK1)
         && hw_set_i == '0 && hw_clr_i == '0)
        |=> ($stable(pend) && $stable(en) && $stable(irq_o)));
endmodule

bind masked_irq_ctl masked_irq_ctl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .hw_set_i    (hw_set_i),
    .hw_clr_i    (hw_clr_i),
    .pend        (pend),
    .en          (en),
    .irq_o       (irq_o)
);

// File: tb/masked_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module masked_irq_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  set_v = '0;
    logic [7:0]  clr_v = '0;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] m_pend = '0;
    logic [7:0] m_en   = '0;

    always #2 clk = ~clk;

    masked_irq_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_set_i(set_v),
        .hw_clr_i(clr_v), .irq_o(irq)
    );

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one cycle of stimulus, update the model, then compare outputs
    task automatic step(string req, logic w, logic [2:0] a, logic [7:0] d,
                        logic [7:0] s, logic [7:0] c);
        logic [7:0] ackm;
        @(negedge clk);
        wr = w; addr = a; wdata = d; set_v = s; clr_v = c;
        @(posedge clk);
        ackm = (w && a == 3'd2 && d[3:0] < 4'd8) ? (8'd1 << d[2:0]) : 8'd0;
        m_pend = (m_pend & ~(c | ackm)) | s;
        if (w && a == 3'd1) m_en = ~d;
        #1;
        wr = 1'b0; addr = 3'd0; set_v = '0; clr_v = '0;
        #0.5;
        check64(req, rdata, {56'd0, m_pend});
        check64(req, {63'd0, irq}, {63'd0, |(m_pend & m_en)});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check64("R1", rdata, 64'd0);
        check64("R1", {63'd0, irq}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 1'b0, 3'd0, 8'h00, 8'h00, 8'h00);

        // R6: set sweep accumulates pending bits, mask all disabled
        step("R6", 1'b1, 3'd1, 8'hFF, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++) step("R6", 1'b0, 3'd0, 8'h00, 8'd1 << i, 8'h00);

        // R2 R4 R5: sweep every mask value with all lines pending
        for (int v = 0; v < 256; v++) step("R2_R5", 1'b1, 3'd1, 8'(v), 8'h00, 8'h00);
        step("R5", 1'b1, 3'd1, 8'h00, 8'h00, 8'h00);
        step("R5", 1'b1, 3'd1, 8'hFF, 8'h00, 8'h00);

        // R3: every acknowledge index, with junk in the upper nibble
        step("R3", 1'b1, 3'd1, 8'h00, 8'h00, 8'h00);
        for (int i = 15; i >= 0; i--) step("R3", 1'b1, 3'd2, 8'((i * 37) & 8'hF0 | i), 8'h00, 8'h00);
        for (int p = 0; p < 256; p += 17) begin
            step("R6", 1'b0, 3'd0, 8'h00, 8'(p), 8'h00);
            for (int i = 0; i < 16; i++) step("R3", 1'b1, 3'd2, 8'(i), 8'h00, 8'h00);
        end

        // R7 R8: pairwise set/clear patterns including collisions
        for (int s = 0; s < 256; s += 15)
            for (int c = 0; c < 256; c += 23) begin
                step("R7_R8", 1'b0, 3'd0, 8'h00, 8'(s), 8'(c));
                step("R7", 1'b0, 3'd0, 8'h00, 8'h00, 8'(c));
            end
        step("R8", 1'b0, 3'd0, 8'h00, 8'hFF, 8'h00);
        for (int i = 0; i < 8; i++) step("R8", 1'b1, 3'd2, 8'(i), 8'd1 << i, 8'h00);

        // R10: bank-1 writes leave state alone; other addresses read zero
        step("R10", 1'b1, 3'd1, 8'hAA, 8'h00, 8'h00);
        for (int v = 0; v < 256; v += 5) begin
            step("R10", 1'b1, 3'd5, 8'(v), 8'h00, 8'h00);
            step("R10", 1'b1, 3'd6, 8'(v & 15), 8'h00, 8'h00);
        end
        @(negedge clk);
        for (int a = 1; a < 8; a++) begin
            addr = 3'(a);
            #0.5;
            check64("R10", rdata, 64'd0);
        end
        addr = 3'd0;
        #0.5;
        check64("R9", rdata, {56'd0, m_pend});

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule